// File: doc/BRIEF.md
# Time-Base Bit-Select Interval Timers

This block keeps a free-running 64-bit time base. From it, the block derives two periodic events: a fixed-interval tick and a watchdog tick. Each event watches one time-base bit and fires when that bit goes from 0 to 1. The period is therefore a power of two, picked by the bit position.

A 32-bit control word sets the period for each event. The period is given as a 2-bit coarse code plus a 4-bit refinement, and the resulting bit index is counted down from the top bit. The control word also holds the interrupt enables. A 32-bit status word keeps sticky flags, and software clears a flag by writing a one to it. Each interrupt line is the flag ANDed with its enable.

Software reaches both words through a one-address-bit synchronous register port. Reads are combinational.

Top module: `tbsel_timers`

## Requirements
- R1: At reset the time base is loaded with parameter TB_INIT. After reset it increases by exactly one on every clock edge, and its value is visible on `tb_value`.
- R2: The control word (addr 0) resets to zero. A write to addr 0 stores all 32 data bits, and the control word does not change on any cycle without such a write.
- R3: The watched bit index is 63 − {ext, base}, where {ext, base} is the 4-bit extension placed above the 2-bit base. For the fixed-interval event, base is control[25:24] and ext is control[16:13]. For the watchdog, base is control[31:30] and ext is control[20:17].
- R4: Consider a cycle in which the watched bit reads 1 and read 0 in the previous cycle, with the same selection. At the end of that cycle, the event's flag is set: status[26] for the fixed-interval event and status[30] for the watchdog. A 1-to-0 change, or a bit that stays high, sets nothing.
- R5: When the bit selection changes, the cycle in which it changes produces no event, even if the newly selected bit reads 1.
- R6: The status word (addr 1) resets to zero. Only bits 31 down to 26 exist, and all other status bits read 0. Bits 31, 29:28 and 27 are only ever cleared, and a control write does not alter the status word.
- R7: A write to addr 1 clears each status bit written as 1 and leaves bits written as 0 unchanged.
- R8: A flag set by an event in the same cycle as a software clear of that flag stays set. A set flag stays set until it is cleared, and repeated events do not queue.
- R9: `fit_irq` equals status[26] AND control[23], and `wdt_irq` equals status[30] AND control[27]. Both follow register changes without an added cycle.
- R10: `rdata` shows the control word when `addr` is 0 and the status word when `addr` is 1, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| addr | input | 1 | 0 selects control, 1 selects status |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word selected by `addr` |
| tb_value | output | 64 | Current time-base count |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| wdt_irq | output | 1 | Watchdog interrupt request |

## Verification
The bench builds the block with TB_INIT = 64'h7FFF_FFFF_FFFF_FF00. With that value, the rising edge of bit 63 arrives about 256 cycles after reset, so the reset-default selection of index 63 can be exercised for both events. Because the low byte starts at zero, the low indices reachable through the extension fields (bits 0, 2 and 3) have predictable edge cycles. This lets the bench time selection changes against bits that are already high, and time clears against cycles in which an event lands.

// File: rtl/tbsel_pkg.sv
`timescale 1ns/1ps
// Shared constants for the bit-select interval timers: widths, register
// field positions and the period-to-bit-index mapping.
// Assumes a 64-bit time base and 32-bit registers.
package tbsel_pkg;
    localparam int TB_W    = 64;
    localparam int REG_W   = 32;
    localparam int SEL_W   = $clog2(TB_W);
    localparam int BASE_W  = 2;
    localparam int EXT_W   = 4;
    localparam int NUM_EVT = 2;

    // event slots
    localparam int EVT_FIT = 0;
    localparam int EVT_WDT = 1;

    // register addresses
    typedef enum logic {
        ADDR_CTRL = 1'b0,
        ADDR_STAT = 1'b1
    } reg_addr_e;

    // control word bit positions
    localparam int C_WDT_BASE_LO = 30;
    localparam int C_WDT_RST_LO  = 28;
    localparam int C_WDT_IE      = 27;
    localparam int C_DEC_IE      = 26;
    localparam int C_FIT_BASE_LO = 24;
    localparam int C_FIT_IE      = 23;
    localparam int C_AUTO_RLD    = 22;
    localparam int C_WDT_EXT_LO  = 17;
    localparam int C_FIT_EXT_LO  = 13;

    // status word bit positions
    localparam int S_NEXT_WD     = 31;
    localparam int S_WDT_FLAG    = 30;
    localparam int S_WDT_RST_LO  = 28;
    localparam int S_DEC_FLAG    = 27;
    localparam int S_FIT_FLAG    = 26;
    localparam logic [REG_W-1:0] STAT_MASK = 32'hFC00_0000;

    // index of the watched bit: counted down from the top bit
    function automatic logic [SEL_W-1:0] bit_index(input logic [BASE_W-1:0] base,
                                                   input logic [EXT_W-1:0]  ext);
        return SEL_W'(TB_W - 1) - {ext, base};
    endfunction

    function automatic int evt_base_lo(input int slot);
        return (slot == EVT_FIT) ? C_FIT_BASE_LO : C_WDT_BASE_LO;
    endfunction

    function automatic int evt_ext_lo(input int slot);
        return (slot == EVT_FIT) ? C_FIT_EXT_LO : C_WDT_EXT_LO;
    endfunction
endpackage

// File: rtl/tbsel_timebase.sv
`timescale 1ns/1ps
// Free-running time-base counter.
// Loads INIT under reset and then counts up by one per clock, wrapping at
// the top. Assumes reset is held for at least one clock edge.
module tbsel_timebase
    import tbsel_pkg::*;
#(
    parameter logic [TB_W-1:0] INIT = '0
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [TB_W-1:0] tb_q
);

    // count every cycle, reload on reset
    always_ff @(posedge clk) begin
        if (!rst_n) tb_q <= INIT;
        else        tb_q <= tb_q + TB_W'(1);
    end

    AST_TB_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (tb_q - $past(tb_q)) == TB_W'(1)); // R1

endmodule

// File: rtl/tbsel_edge.sv
`timescale 1ns/1ps
// Bit selector and rising-edge detector for one timer event.
// Picks the time-base bit named by {ext, base}, counted down from the top,
// and pulses evt for one cycle when that bit goes 0->1 under an unchanged
// selection. The cycle in which the selection changes only re-arms the
// history, so a selection change never fires by itself.
module tbsel_edge
    import tbsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TB_W-1:0]   tb,
    input  logic [BASE_W-1:0] base,
    input  logic [EXT_W-1:0]  ext,
    output logic              evt
);

    logic [SEL_W-1:0] idx;
    logic [SEL_W-1:0] idx_q;
    logic             cur;
    logic             prev_q;
    logic             armed_q;

    // decode selection and pick the watched bit
    always_comb begin
        idx = bit_index(base, ext);
        cur = tb[idx];
    end

    // remember last bit value and the selection it came from
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            idx_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            prev_q  <= cur;
            idx_q   <= idx;
            armed_q <= 1'b1;
        end
    end

    // fire on a 0->1 change seen under the same selection
    assign evt = armed_q && (idx == idx_q) && cur && !prev_q;

    AST_RISE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (cur && !$past(cur))); // R4

    AST_SEL_CHANGE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (idx != $past(idx)) |-> !evt); // R5

endmodule

// File: rtl/tbsel_regs.sv
`timescale 1ns/1ps
// Control and status registers with the read multiplexer.
// Control is fully writable storage. Status holds sticky event flags with
// write-one-to-clear; an event set wins over a clear in the same cycle.
// Assumes a single-cycle write strobe and combinational reads.
module tbsel_regs
    import tbsel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               addr,
    input  logic [REG_W-1:0]   wdata,
    input  logic [NUM_EVT-1:0] evt,
    output logic [REG_W-1:0]   ctrl_q,
    output logic [REG_W-1:0]   stat_q,
    output logic [REG_W-1:0]   rdata
);

    logic             ctrl_we;
    logic             stat_we;
    logic [REG_W-1:0] clr;
    logic [REG_W-1:0] set;
    logic [REG_W-1:0] stat_d;

    // decode the write strobe per register
    always_comb begin
        ctrl_we = wr_en && (addr == ADDR_CTRL);
        stat_we = wr_en && (addr == ADDR_STAT);
    end

    // next status: clear written ones, then apply event sets
    always_comb begin
        clr = stat_we ? wdata : '0;
        set = '0;
        set[S_FIT_FLAG] = evt[EVT_FIT];
        set[S_WDT_FLAG] = evt[EVT_WDT];
        stat_d = ((stat_q & ~clr) | set) & STAT_MASK;
    end

    // control storage
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (ctrl_we) ctrl_q <= wdata;
    end

    // status flags
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    // read multiplexer
    assign rdata = (addr == ADDR_STAT) ? stat_q : ctrl_q;

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_CTRL) |=> $stable(ctrl_q)); // R2

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_STAT && wdata[S_WDT_FLAG] && !evt[EVT_WDT])
        |=> !stat_q[S_WDT_FLAG]); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_q[S_FIT_FLAG] && !(wr_en && addr == ADDR_STAT && wdata[S_FIT_FLAG]))
        |=> stat_q[S_FIT_FLAG]); // R8

endmodule

// File: rtl/tbsel_timers.sv
`timescale 1ns/1ps
// Top level of the bit-select interval timers.
// Wires the time base, one edge detector per event (fixed-interval and
// watchdog, built by a generate loop from the package field table), the
// register file and the interrupt gating. Interrupts are combinational.
module tbsel_timers
    import tbsel_pkg::*;
#(
    parameter logic [63:0] TB_INIT = '0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic        addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    output logic [63:0] tb_value,
    output logic        fit_irq,
    output logic        wdt_irq
);

    logic [TB_W-1:0]    tb_q;
    logic [REG_W-1:0]   ctrl_q;
    logic [REG_W-1:0]   stat_q;
    logic [NUM_EVT-1:0] evt;

    tbsel_timebase #(.INIT(TB_INIT)) u_tb (
        .clk  (clk),
        .rst_n(rst_n),
        .tb_q (tb_q)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        localparam int BLO = evt_base_lo(g);
        localparam int ELO = evt_ext_lo(g);
        tbsel_edge u_edge (
            .clk  (clk),
            .rst_n(rst_n),
            .tb   (tb_q),
            .base (ctrl_q[BLO +: BASE_W]),
            .ext  (ctrl_q[ELO +: EXT_W]),
            .evt  (evt[g])
        );
    end

    tbsel_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wdata (wdata),
        .evt   (evt),
        .ctrl_q(ctrl_q),
        .stat_q(stat_q),
        .rdata (rdata)
    );

    // gate flags with their enables
    always_comb begin
        fit_irq = stat_q[S_FIT_FLAG] & ctrl_q[C_FIT_IE];
        wdt_irq = stat_q[S_WDT_FLAG] & ctrl_q[C_WDT_IE];
    end

    assign tb_value = tb_q;

    AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        evt[EVT_WDT] |=> stat_q[S_WDT_FLAG]); // R8

endmodule

// File: tb/sim_tbsel_timers.sv
`timescale 1ns/1ps
module sim_tbsel_timers;
    localparam logic [63:0] INIT = 64'h7FFF_FFFF_FFFF_FF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        addr = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [63:0] tb_value;
    logic        fit_irq;
    logic        wdt_irq;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    tbsel_timers #(.TB_INIT(INIT)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tb_value(tb_value), .fit_irq(fit_irq), .wdt_irq(wdt_irq)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wdata = '0; addr = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic wait_tb(input logic [63:0] mask, input logic [63:0] val);
        while ((tb_value & mask) != val) @(negedge clk);
    endtask

    // reset values, counting, control storage, read select
    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        rd(1'b0, d); chk("R2 ctrl reset", d, 0);
        rd(1'b1, d); chk("R6 status reset", d, 0);
        chk("R9 irqs at reset", {fit_irq, wdt_irq}, 0);
        chk("R1 tb init", tb_value, INIT);
        @(negedge clk);
        chk("R1 tb step", tb_value, INIT + 1);
        wr(1'b0, 32'h3440_0001);
        rd(1'b0, d); chk("R2 ctrl stores all bits", d, 32'h3440_0001);
        rd(1'b1, d); chk("R10 status selected, R6 untouched by ctrl write", d, 0);
    endtask

    // default selection index 63, irq gating, write-one-to-clear
    task automatic t_bit63();
        logic [31:0] d;
        do_reset();
        wait_tb(64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_0000);
        rd(1'b1, d); chk("R4 no flag in edge cycle", d, 0);
        @(negedge clk);
        rd(1'b1, d); chk("R3 bit63 sets both flags", d, 32'h4400_0000);
        chk("R9 irqs masked", {fit_irq, wdt_irq}, 0);
        wr(1'b0, 32'h0080_0000);
        chk("R9 fit enable immediate", {fit_irq, wdt_irq}, 2'b10);
        wr(1'b0, 32'h0880_0000);
        chk("R9 wdt enable immediate", {fit_irq, wdt_irq}, 2'b11);
        wr(1'b1, 32'h4000_0000);
        rd(1'b1, d); chk("R7 clear only wdt flag", d, 32'h0400_0000);
        chk("R9 wdt irq drops", {fit_irq, wdt_irq}, 2'b10);
        wr(1'b1, 32'h0000_0000);
        rd(1'b1, d); chk("R7 zero write keeps flags", d, 32'h0400_0000);
        wr(1'b1, 32'hFFFF_FFFF);
        rd(1'b1, d); chk("R7 clear all", d, 0);
        chk("R9 fit irq drops", fit_irq, 0);
        repeat (20) @(negedge clk);
        rd(1'b1, d); chk("R4 held-high bit does not refire", d, 0);
    endtask

    // low-bit selection, selection change quiet, falling edge quiet
    task automatic t_select();
        logic [31:0] d;
        logic        quiet;
        do_reset();
        wait_tb(64'hF, 64'h8);
        wr(1'b0, 32'h031F_E000);          // fit idx 0, wdt idx 3; tb now ..9
        rd(1'b0, d); chk("R2 ctrl readback", d, 32'h031F_E000);
        rd(1'b1, d); chk("R5 no event on selection change", d, 0);
        @(negedge clk);
        rd(1'b1, d); chk("R5 still quiet", d, 0);
        @(negedge clk);                    // ..B: fit edge cycle
        rd(1'b1, d); chk("R4 fit flag not yet", d[26], 0);
        @(negedge clk);                    // ..C
        rd(1'b1, d); chk("R3 fit on bit 0", d[26], 1);
        quiet = 1'b1;
        while (tb_value[3:0] != 4'h8) begin
            rd(1'b1, d);
            if (d[30]) quiet = 1'b0;
            @(negedge clk);
        end
        rd(1'b1, d);
        chk("R4 wdt quiet across falling edge", {quiet, d[30]}, 2'b10);
        @(negedge clk);
        rd(1'b1, d); chk("R3 wdt on bit 3", d[30], 1);
    endtask

    // another extension combination: watchdog on bit 2
    task automatic t_ext();
        logic [31:0] d;
        do_reset();
        wr(1'b0, 32'h401E_0000);
        wait_tb(64'h7, 64'h4);
        rd(1'b1, d); chk("R3 wdt bit2 not yet", d, 0);
        @(negedge clk);
        rd(1'b1, d); chk("R3 wdt on bit 2", d, 32'h4000_0000);
    endtask

    // set beats clear in same cycle; clear alone works; no queueing
    task automatic t_setwins();
        logic [31:0] d;
        do_reset();
        wr(1'b0, 32'h0381_E000);
        repeat (4) @(negedge clk);
        wait_tb(64'h1, 64'h1);             // fit edge cycle
        wr(1'b1, 32'h0400_0000);
        rd(1'b1, d); chk("R8 set wins over clear", d[26], 1);
        chk("R9 fit irq on", fit_irq, 1);
        wr(1'b1, 32'h0400_0000);           // even cycle: no event
        rd(1'b1, d); chk("R7 clear without event", d[26], 0);
        chk("R9 fit irq off", fit_irq, 0);
        @(negedge clk);
        rd(1'b1, d); chk("R8 next event sets again", d, 32'h0400_0000);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL timeout actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_bit63();
        t_select();
        t_ext();
        t_setwins();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule